// File: doc/BRIEF.md
# Shared interrupt source controller

This block conditions a set of external interrupt lines and steers each one to interrupt outputs on several processor contexts. Every source passes through a two-flop synchronizer and then an optional inversion. It is then taken either as a level or as an edge. Edge sources are caught in a sticky latch that can fire on one edge or on both edges. Software can force that latch on or off with a single command word. A source reaches a context only when it is enabled in the mask, routed by its route word and selected in its destination map.

Software drives the block through a plain 32-bit register port with word addresses. Writes take effect on the clock edge where `bus_wr` is high. `bus_rdata` is registered and returns the word at `bus_addr` one edge later.

The word addresses are:
- 0x00: configuration (read-only)
- 0x01: inversion
- 0x02: edge select
- 0x03: both-edge select
- 0x04: edge command (write-only)
- 0x05: mask clear (write-only)
- 0x06: mask set (write-only)
- 0x07: mask (read-only)
- 0x08: pending (read-only)
- 0x40+i: route word of source i
- 0x80+i: destination map of source i

Bit i of each per-source bank belongs to source i. Each context gets a pin vector, an NMI line, an auxiliary line and a vector number. All of these outputs are registered.

Top module: `sic_ctrl`

## Requirements
- R1: After reset the inversion, edge-select, both-edge, mask, route and destination state is all zero, and every output is zero. The configuration word reads NUM_SRC in bits 23:16 and NUM_CTX in bits 7:0, with all other bits zero.
- R2: A write to mask set (0x06) enables each source whose data bit is 1. A write to mask clear (0x05) disables each source whose data bit is 1. Zero bits leave the mask unchanged. The mask reads at 0x07, where a 1 means enabled.
- R3: For a source with edge-select 0, the pending bit (read at 0x08, independent of the mask) equals the synchronized input XOR its inversion bit.
- R4: For a source with edge-select 1, a 0-to-1 change of the inverted input sets a sticky pending bit. That bit stays set after the input returns, until an edge command clears it.
- R5: With edge-select 1 and both-edge 1, a 1-to-0 change of the inverted input also sets the pending bit. With edge-select 0, the both-edge bit has no effect.
- R6: The edge command (0x04) carries a source number in bits 7:0. Bit 31 = 1 sets that source's latch and bit 31 = 0 clears it. A source number at or above NUM_SRC changes nothing. A hardware edge in the same cycle as a clear wins.
- R7: Output bit ctx_pin_o[c*NUM_PIN+p] is the OR of all sources that are pending, enabled, have route bit 31 set, have pin field bits 5:0 equal to p, and have bit c set in their destination map. A pin field of NUM_PIN or above drives no pin.
- R8: ctx_nmi_o[c] and ctx_aux_o[c] are formed the same way from route bit 30 and route bit 29 respectively, independent of bit 31.
- R9: ctx_vec_o[c*8 +: 8] equals one plus the highest active pin number of context c, or zero when no pin of that context is active.
- R10: For an enabled level source, a change of its input applied between clock edges appears on its pin output after the third rising edge.
- R11: The route word reads back as bits 31, 30, 29 and 5:0 only. The destination map reads back only its low NUM_CTX bits. The write-only addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| ctx_pin_o | output | NUM_CTX*NUM_PIN | Core interrupt pins, context-major |
| ctx_nmi_o | output | NUM_CTX | NMI line per context |
| ctx_aux_o | output | NUM_CTX | Auxiliary interrupt line per context |
| ctx_vec_o | output | NUM_CTX*8 | Vector number per context |

## Verification
The bench builds the block with 8 sources, 4 pins and 2 contexts. At that size it can walk every source through every pin number, plus one out-of-range pin number, and both contexts. Inputs and inversion bits are swept across all 256 patterns, and each pending word is predicted with XOR in the bench. The small size also keeps single-edge, both-edge and command paths, the three-edge latency and out-of-range command numbers cheap to cover one by one.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int ADDR_W = 8;
  localparam int PIN_W  = 6;
  localparam int VEC_W  = 8;

  localparam logic [ADDR_W-1:0] A_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] A_INV  = 8'h01;
  localparam logic [ADDR_W-1:0] A_EDG  = 8'h02;
  localparam logic [ADDR_W-1:0] A_BOTH = 8'h03;
  localparam logic [ADDR_W-1:0] A_CMD  = 8'h04;
  localparam logic [ADDR_W-1:0] A_MCLR = 8'h05;
  localparam logic [ADDR_W-1:0] A_MSET = 8'h06;
  localparam logic [ADDR_W-1:0] A_MASK = 8'h07;
  localparam logic [ADDR_W-1:0] A_PEND = 8'h08;
  localparam logic [1:0] BANK_ROUTE = 2'b01;
  localparam logic [1:0] BANK_DEST  = 2'b10;

  typedef struct packed {
    logic             to_pin;
    logic             to_nmi;
    logic             to_aux;
    logic [PIN_W-1:0] pin;
  } route_t;
endpackage

// File: rtl/sic_src_cond.sv
module sic_src_cond (
  input  logic clk,
  input  logic rst,
  input  logic in_raw,
  input  logic inv,
  input  logic edge_sel,
  input  logic both,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pend_o
);
  logic sync1_q, sync2_q, lvl_q, latch_q;
  logic lvl, hw_edge;

  assign lvl     = sync2_q ^ inv;
  assign hw_edge = edge_sel & (both ? (lvl ^ lvl_q) : (lvl & ~lvl_q));
  assign pend_o  = edge_sel ? latch_q : lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      lvl_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sync1_q <= in_raw;
      sync2_q <= sync1_q;
      lvl_q   <= lvl;
      if (hw_edge || sw_set)
        latch_q <= 1'b1;
      else if (sw_clr)
        latch_q <= 1'b0;
    end
  end

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (latch_q && !sw_clr) |=> latch_q);
  // R6
  latch_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !hw_edge && !sw_set) |=> !latch_q);
  // R4
  latch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_q) |-> $past(hw_edge || sw_set));
endmodule

// File: rtl/sic_router.sv
module sic_router
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_PIN = 6,
  parameter int NUM_CTX = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_SRC-1:0]                active,
  input  route_t                            routes [NUM_SRC],
  input  logic [NUM_SRC-1:0][NUM_CTX-1:0]   dest,
  output logic [NUM_CTX-1:0][NUM_PIN-1:0]   pin_q,
  output logic [NUM_CTX-1:0]                nmi_q,
  output logic [NUM_CTX-1:0]                aux_q,
  output logic [NUM_CTX-1:0][VEC_W-1:0]     vec_q
);
  logic [NUM_CTX-1:0][NUM_PIN-1:0] pin_d;
  logic [NUM_CTX-1:0]              nmi_d, aux_d;
  logic [NUM_CTX-1:0][VEC_W-1:0]   vec_d;

  always_comb begin
    pin_d = '0;
    nmi_d = '0;
    aux_d = '0;
    vec_d = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (active[s] && dest[s][c]) begin
          if (routes[s].to_nmi) nmi_d[c] = 1'b1;
          if (routes[s].to_aux) aux_d[c] = 1'b1;
          for (int p = 0; p < NUM_PIN; p++)
            if (routes[s].to_pin && routes[s].pin == PIN_W'(p))
              pin_d[c][p] = 1'b1;
        end
      end
      for (int p = 0; p < NUM_PIN; p++)
        if (pin_d[c][p]) vec_d[c] = VEC_W'(p + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= '0;
      nmi_q <= '0;
      aux_q <= '0;
      vec_q <= '0;
    end else begin
      pin_q <= pin_d;
      nmi_q <= nmi_d;
      aux_q <= aux_d;
      vec_q <= vec_d;
    end
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (pin_q[c] == '0) |-> (vec_q[c] == '0));
    // R9
    vec_range_chk: assert property (@(posedge clk) disable iff (rst)
      (pin_q[c] != '0) |-> (vec_q[c] != '0 && vec_q[c] <= VEC_W'(NUM_PIN)));
  end
endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl
  import sic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_PIN = 6,
  parameter int NUM_CTX = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         irq_in,
  input  logic                       bus_wr,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic [NUM_CTX*NUM_PIN-1:0] ctx_pin_o,
  output logic [NUM_CTX-1:0]         ctx_nmi_o,
  output logic [NUM_CTX-1:0]         ctx_aux_o,
  output logic [NUM_CTX*VEC_W-1:0]   ctx_vec_o
);
  localparam logic [31:0] CFG_WORD = {8'h00, 8'(NUM_SRC), 8'h00, 8'(NUM_CTX)};

  logic [NUM_SRC-1:0] inv_q, edg_q, both_q, mask_q, pend;
  logic [NUM_SRC-1:0] sw_set, sw_clr;
  route_t             routes [NUM_SRC];
  logic [NUM_SRC-1:0][NUM_CTX-1:0] dest_q;
  logic [31:0]        rd_d;
  logic               wr_cmd;

  assign wr_cmd = bus_wr && bus_addr == A_CMD;

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q  <= '0;
      edg_q  <= '0;
      both_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_INV:  inv_q  <= bus_wdata[NUM_SRC-1:0];
        A_EDG:  edg_q  <= bus_wdata[NUM_SRC-1:0];
        A_BOTH: both_q <= bus_wdata[NUM_SRC-1:0];
        A_MSET: mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
        A_MCLR: mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic hit_cmd;
    assign hit_cmd   = wr_cmd && bus_wdata[7:0] == 8'(s);
    assign sw_set[s] = hit_cmd && bus_wdata[31];
    assign sw_clr[s] = hit_cmd && !bus_wdata[31];

    always_ff @(posedge clk) begin
      if (rst) begin
        routes[s] <= '0;
        dest_q[s] <= '0;
      end else if (bus_wr && bus_addr[5:0] == 6'(s)) begin
        if (bus_addr[7:6] == BANK_ROUTE)
          routes[s] <= '{to_pin: bus_wdata[31], to_nmi: bus_wdata[30],
                         to_aux: bus_wdata[29], pin: bus_wdata[PIN_W-1:0]};
        else if (bus_addr[7:6] == BANK_DEST)
          dest_q[s] <= bus_wdata[NUM_CTX-1:0];
      end
    end

    sic_src_cond i_cond (
      .clk      (clk),
      .rst      (rst),
      .in_raw   (irq_in[s]),
      .inv      (inv_q[s]),
      .edge_sel (edg_q[s]),
      .both     (both_q[s]),
      .sw_set   (sw_set[s]),
      .sw_clr   (sw_clr[s]),
      .pend_o   (pend[s])
    );
  end

  always_comb begin
    rd_d = '0;
    case (bus_addr)
      A_CFG:  rd_d = CFG_WORD;
      A_INV:  rd_d = 32'(inv_q);
      A_EDG:  rd_d = 32'(edg_q);
      A_BOTH: rd_d = 32'(both_q);
      A_MASK: rd_d = 32'(mask_q);
      A_PEND: rd_d = 32'(pend);
      default: begin
        for (int s = 0; s < NUM_SRC; s++) begin
          if (bus_addr[5:0] == 6'(s)) begin
            if (bus_addr[7:6] == BANK_ROUTE)
              rd_d = {routes[s].to_pin, routes[s].to_nmi, routes[s].to_aux,
                      {(29-PIN_W){1'b0}}, routes[s].pin};
            else if (bus_addr[7:6] == BANK_DEST)
              rd_d = 32'(dest_q[s]);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end

  logic [NUM_CTX-1:0][NUM_PIN-1:0] pin_q;
  logic [NUM_CTX-1:0][VEC_W-1:0]   vec_q;

  sic_router #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN), .NUM_CTX(NUM_CTX)) i_router (
    .clk    (clk),
    .rst    (rst),
    .active (pend & mask_q),
    .routes (routes),
    .dest   (dest_q),
    .pin_q  (pin_q),
    .nmi_q  (ctx_nmi_o),
    .aux_q  (ctx_aux_o),
    .vec_q  (vec_q)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_out
    assign ctx_pin_o[c*NUM_PIN +: NUM_PIN] = pin_q[c];
    assign ctx_vec_o[c*VEC_W +: VEC_W]     = vec_q[c];
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_MSET) |=>
      ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_MCLR) |=>
      ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));
  // R2
  mask_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && (bus_addr == A_MSET || bus_addr == A_MCLR)) |=> $stable(mask_q));
  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> (ctx_pin_o == '0 && ctx_nmi_o == '0 && ctx_aux_o == '0));
endmodule

// File: tb/test_sic_ctrl.sv
module test_sic_ctrl;
  localparam int NS = 8;
  localparam int NP = 4;
  localparam int NC = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NS-1:0]     irq_in = '0;
  logic              bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NC*NP-1:0]  ctx_pin_o;
  logic [NC-1:0]     ctx_nmi_o, ctx_aux_o;
  logic [NC*8-1:0]   ctx_vec_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  sic_ctrl #(.NUM_SRC(NS), .NUM_PIN(NP), .NUM_CTX(NC)) i_sic_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctx_pin_o(ctx_pin_o),
    .ctx_nmi_o(ctx_nmi_o), .ctx_aux_o(ctx_aux_o), .ctx_vec_o(ctx_vec_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 pins", 32'(ctx_pin_o), 0);
    chk("R1 vec", 32'(ctx_vec_o), 0);
    chk("R1 nmi/aux", 32'({ctx_nmi_o, ctx_aux_o}), 0);
    rd(8'h00, rv); chk("R1 cfg", rv, (NS << 16) | NC);
    rd(8'h07, rv); chk("R1 mask", rv, 0);
    rd(8'h01, rv); chk("R1 inv", rv, 0);
    rd(8'h02, rv); chk("R1 edge", rv, 0);
    rd(8'h40 + 3, rv); chk("R1 route", rv, 0);

    // R2 mask set/clear
    wr(8'h06, 32'hA5); rd(8'h07, rv); chk("R2 set", rv, 32'hA5);
    wr(8'h06, 32'h0);  rd(8'h07, rv); chk("R2 set zero", rv, 32'hA5);
    wr(8'h05, 32'h05); rd(8'h07, rv); chk("R2 clr", rv, 32'hA0);
    wr(8'h05, 32'h0);  rd(8'h07, rv); chk("R2 clr zero", rv, 32'hA0);
    wr(8'h06, 32'hFF); rd(8'h07, rv); chk("R2 set all", rv, 32'hFF);

    // R3 level pending sweep
    for (int pat = 0; pat < 256; pat++) begin
      logic [7:0] pv;
      pv = 8'((pat * 37) >> 3);
      wr(8'h01, 32'(pv));
      irq_in = 8'(pat);
      idle(4);
      rd(8'h08, rv);
      chk("R3 pend", rv, 32'(8'(pat) ^ pv));
    end
    wr(8'h01, 0); irq_in = '0; idle(4);

    // R7 R9 routing sweep, pin NP is out of range
    for (int s = 0; s < NS; s++) begin
      for (int p = 0; p <= NP; p++) begin
        for (int c = 0; c < NC; c++) begin
          wr(8'h40 + 8'(s), 32'h8000_0000 | p);
          wr(8'h80 + 8'(s), 32'(1 << c));
          irq_in = 8'(1 << s);
          idle(4);
          chk("R7 pin", 32'(ctx_pin_o), (p < NP) ? 32'(1 << (c*NP + p)) : 0);
          chk("R9 vec", 32'(ctx_vec_o), (p < NP) ? 32'((p + 1) << (8*c)) : 0);
          if (p == 0 && c == 0) begin
            wr(8'h05, 32'(1 << s)); idle(2);
            chk("R7 masked", 32'(ctx_pin_o), 0);
            wr(8'h06, 32'(1 << s));
          end
          irq_in = '0;
          wr(8'h40 + 8'(s), 0);
          idle(4);
        end
      end
    end

    // R9 highest pin wins
    wr(8'h40 + 1, 32'h8000_0001); wr(8'h80 + 1, 1);
    wr(8'h40 + 2, 32'h8000_0003); wr(8'h80 + 2, 1);
    irq_in = 8'h06; idle(4);
    chk("R9 two pins vec", 32'(ctx_vec_o), 4);
    chk("R9 two pins pin", 32'(ctx_pin_o), 32'h0A);
    irq_in = 8'h02; idle(4);
    chk("R9 lower pin vec", 32'(ctx_vec_o), 2);
    irq_in = '0;
    wr(8'h40 + 1, 0); wr(8'h40 + 2, 0); idle(4);

    // R8 nmi and aux
    wr(8'h40 + 2, 32'h4000_0000); wr(8'h80 + 2, 2);
    irq_in = 8'h04; idle(4);
    chk("R8 nmi", 32'(ctx_nmi_o), 2);
    chk("R8 aux off", 32'(ctx_aux_o), 0);
    chk("R8 no pin", 32'(ctx_pin_o), 0);
    wr(8'h40 + 2, 32'h2000_0000); idle(3);
    chk("R8 aux", 32'(ctx_aux_o), 2);
    chk("R8 nmi off", 32'(ctx_nmi_o), 0);
    irq_in = '0; wr(8'h40 + 2, 0); idle(4);

    // R4 single edge on source 4
    wr(8'h02, 32'h10); wr(8'h04, 4); idle(2);
    rd(8'h08, rv); chk("R4 idle", rv & 32'h10, 0);
    irq_in[4] = 1'b1; idle(4);
    rd(8'h08, rv); chk("R4 rise", rv & 32'h10, 32'h10);
    irq_in[4] = 1'b0; idle(4);
    rd(8'h08, rv); chk("R4 sticky", rv & 32'h10, 32'h10);
    wr(8'h04, 4); idle(1);
    rd(8'h08, rv); chk("R4 cleared", rv & 32'h10, 0);

    // R5 both edges on source 5
    wr(8'h02, 32'h20); wr(8'h03, 32'h20); wr(8'h04, 5); idle(2);
    irq_in[5] = 1'b1; idle(4); wr(8'h04, 5); idle(1);
    rd(8'h08, rv); chk("R5 after clear", rv & 32'h20, 0);
    irq_in[5] = 1'b0; idle(4);
    rd(8'h08, rv); chk("R5 fall latches", rv & 32'h20, 32'h20);
    wr(8'h03, 0); wr(8'h04, 5); idle(1);
    irq_in[5] = 1'b1; idle(4); wr(8'h04, 5);
    irq_in[5] = 1'b0; idle(4);
    rd(8'h08, rv); chk("R5 single fall ignored", rv & 32'h20, 0);
    wr(8'h02, 0); wr(8'h03, 32'h20);
    irq_in[5] = 1'b1; idle(4);
    rd(8'h08, rv); chk("R5 level high", rv & 32'h20, 32'h20);
    irq_in[5] = 1'b0; idle(4);
    rd(8'h08, rv); chk("R5 level low", rv & 32'h20, 0);
    wr(8'h03, 0);

    // R6 software edge command
    wr(8'h02, 32'h40);
    wr(8'h04, 32'h8000_0006); idle(1);
    rd(8'h08, rv); chk("R6 sw set", rv, 32'h40);
    wr(8'h04, 6); idle(1);
    rd(8'h08, rv); chk("R6 sw clr", rv, 0);
    wr(8'h04, 32'h8000_0000 | NS); idle(1);
    rd(8'h08, rv); chk("R6 out of range", rv, 0);
    wr(8'h02, 0);

    // R10 latency on source 0, pin 0, context 0
    wr(8'h40, 32'h8000_0000); wr(8'h80, 1); idle(4);
    @(negedge clk); irq_in[0] = 1'b1;
    @(negedge clk); chk("R10 edge1", 32'(ctx_pin_o), 0);
    @(negedge clk); chk("R10 edge2", 32'(ctx_pin_o), 0);
    @(negedge clk); chk("R10 edge3", 32'(ctx_pin_o), 1);
    irq_in = '0;

    // R11 read-back widths
    wr(8'h40 + 7, 32'hFFFF_FFFF); rd(8'h40 + 7, rv); chk("R11 route", rv, 32'hE000_003F);
    wr(8'h80 + 7, 32'hFF); rd(8'h80 + 7, rv); chk("R11 dest", rv, 32'h3);
    rd(8'h04, rv); chk("R11 cmd reads 0", rv, 0);
    rd(8'h06, rv); chk("R11 mset reads 0", rv, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule